// File: doc/BRIEF.md
# Dual Dead-Time Extremum-Seeking Adapter

This block tunes two dead-time curves of a synchronous buck converter while it runs, by searching for the timing that gives the lowest measured power loss. Each curve is held as a small set of vertices along the load-current axis. The block adds a small square-wave dither to each dead-time command. The two dithers run at different rates, so their effects can be told apart. At each slow sample strobe the block takes a loss sample and, when the load is above one ampere, divides it by the load current. A first-order high-pass filter then removes the DC level. The block multiplies the result by each dither's sign, delayed by a fixed number of samples, to form a gradient estimate per curve.

The gradient moves the two vertices that bracket the present load current downhill. Each step is scaled by that vertex's interpolation weight and clamped to a legal dead-time window. The new pair of values is sent out as a write-back. For a few samples after every change of the delayed dither sign, the correlation is skipped. An enable input freezes the dither, the filter, the delay lines and the vertices. The lookup index and weight come from an external interpolator that also produces the dead-time commands.

Top module: `es_deadtime_adapter`

## Requirements
- R1: After reset no write-back is valid, both dither signs are positive, every vertex of both curves holds DT_INIT, and the filter average is zero.
- R2: While enabled, each dither output is +AMP or -AMP in two's complement. Channel 0 holds a sign for HALF0 accepted samples and channel 1 for HALF1 accepted samples. The sign is positive first.
- R3: While `en` is low, both dither outputs are zero and no write-back is issued. Dither counters, delay lines, filter state and vertices keep their values until `en` returns high.
- R4: The cost of an accepted sample is floor(loss / iload) when iload exceeds ONE_AMP, and loss otherwise.
- R5: The filtered cost is hp = cost - avg. After each accepted sample, avg becomes avg + (hp >>> HPS), where >>> is an arithmetic shift.
- R6: Each channel's gradient is +hp when its dither sign from DLY accepted samples earlier was positive, and -hp when it was negative.
- R7: When a channel's delayed sign differs from the delayed sign used at the previous accepted sample, that sample and the next DISC-1 accepted samples issue no write-back on that channel.
- R8: For an accepted, non-skipped sample with index i (0..NV-2) and weight w (0..2^WW-1, weight of vertex i+1), vertex i decreases by (g*(2^WW-w)) >>> (WW+GSH) and vertex i+1 decreases by (g*w) >>> (WW+GSH). No other vertex changes. The clock edge that takes the strobe registers `wb_vld`, `wb_idx`=i, `wb_lo` (new vertex i) and `wb_hi` (new vertex i+1).
- R9: Every updated vertex is clamped to the range DT_MIN..DT_MAX.
- R10: The two channels share the cost but keep their own dither, delay, skip window and vertex set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Adaptation enable |
| smp_vld | input | 1 | Sample strobe; a sample is accepted when high together with en |
| loss | input | LW | Unsigned loss measurement |
| iload | input | IW | Unsigned load current, ONE_AMP counts per ampere |
| seg_idx | input | $clog2(NV) | Index of the lower bracketing vertex |
| seg_w | input | WW | Weight of the upper bracketing vertex, in units of 2^-WW |
| dith | output | 2 x DTW | Per-channel dither offset, two's complement |
| wb_vld | output | 2 | Per-channel write-back valid |
| wb_idx | output | $clog2(NV) | Lower vertex index of the write-back |
| wb_lo | output | 2 x DTW | New value of the lower vertex per channel |
| wb_hi | output | 2 x DTW | New value of the upper vertex per channel |

## Verification
The assertions assume that `seg_idx` never exceeds NV-2 and that `iload` is no wider than `loss`. The bench keeps the index in range by taking it modulo NV-1, and the default widths meet the width rule. Loss sweeps, saturation drives and the enable-off window all stay inside these limits. The assertions also assume that `seg_w` matches the index that goes with it. Any weight meets this, because the block does not read the weight for consistency. The bench sweeps every weight value for every index.

// File: rtl/es_pkg.sv
// Shared types and helpers for the dead-time adapter.
// Assumes: integer arithmetic fits in 32 bits for the configured widths.
package es_pkg;

    // Sign of a square-wave dither: positive half first.
    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } phase_t;

    // Clamp an integer into [lo, hi].
    function automatic int clamp_i(input int x, input int lo, input int hi);
        if (x < lo) return lo;
        if (x > hi) return hi;
        return x;
    endfunction

endpackage

// File: rtl/es_cost_hpf.sv
// Cost path: optional load normalization, then first-order DC removal.
// Assumes: IW <= LW; adv is the accepted-sample strobe.
module es_cost_hpf #(
    parameter int LW      = 12,
    parameter int IW      = 8,
    parameter int ONE_AMP = 16,
    parameter int HPS     = 2,
    localparam int HW     = LW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic [LW-1:0]        loss,
    input  logic [IW-1:0]        iload,
    output logic signed [HW-1:0] hp
);

    logic [LW-1:0]        il_ext;
    logic [LW-1:0]        cost;
    logic signed [HW-1:0] avg;

    // Normalize by load current above one ampere.
    always_comb begin
        il_ext = LW'(iload);
        cost   = (il_ext > LW'(ONE_AMP)) ? (loss / il_ext) : loss;
        hp     = $signed({2'b00, cost}) - avg;
    end

    // Track the running average that the high-pass output is taken against.
    always_ff @(posedge clk) begin
        if (!rst_n)   avg <= '0;
        else if (adv) avg <= avg + (hp >>> HPS);
    end

endmodule

// File: rtl/es_dither_gen.sv
// One square-wave dither channel: sign generator, lag line and skip window.
// Assumes: HALF >= 2, DLY >= 1; adv is the accepted-sample strobe.
module es_dither_gen
    import es_pkg::*;
#(
    parameter int HALF = 4,
    parameter int DLY  = 3,
    parameter int DISC = 2,
    localparam int CW  = (HALF > 2) ? $clog2(HALF) : 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   adv,
    output phase_t ph_now,
    output phase_t ph_lag,
    output logic   skip
);

    logic [CW-1:0]  cnt;
    phase_t         dly [DLY];
    phase_t         lag_q;
    logic           edge_seen;

    assign ph_lag    = dly[DLY-1];
    assign edge_seen = (ph_lag != lag_q);

    // Sign generator: flip after HALF accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            ph_now <= PH_POS;
        end else if (adv) begin
            if (cnt == CW'(HALF - 1)) begin
                cnt    <= '0;
                ph_now <= (ph_now == PH_POS) ? PH_NEG : PH_POS;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Lag line: shift the present sign in, DLY samples deep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) dly[i] <= PH_POS;
            lag_q <= PH_POS;
        end else if (adv) begin
            dly[0] <= ph_now;
            for (int i = 1; i < DLY; i++) dly[i] <= dly[i-1];
            lag_q <= ph_lag;
        end
    end

    generate
        if (DISC > 0) begin : g_blank
            localparam int BW = (DISC > 1) ? $clog2(DISC) : 1;
            logic [BW-1:0] blk;
            assign skip = edge_seen || (blk != '0);
            // Count down the remaining samples to drop after a lagged edge.
            always_ff @(posedge clk) begin
                if (!rst_n)               blk <= '0;
                else if (adv) begin
                    if (edge_seen)        blk <= BW'(DISC - 1);
                    else if (blk != '0)   blk <= blk - 1'b1;
                end
            end
        end else begin : g_noblank
            assign skip = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/es_vertex_bank.sv
// Vertex store for one dead-time curve with weighted, clamped gradient steps.
// Assumes: idx <= NV-2; g is the per-channel gradient for this sample.
module es_vertex_bank
    import es_pkg::*;
#(
    parameter int NV      = 4,
    parameter int DTW     = 8,
    parameter int WW      = 4,
    parameter int HW      = 14,
    parameter int GSH     = 4,
    parameter int DT_MIN  = 2,
    parameter int DT_MAX  = 200,
    parameter int DT_INIT = 64,
    localparam int IXW    = $clog2(NV)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd,
    input  logic [IXW-1:0]       idx,
    input  logic [WW-1:0]        w,
    input  logic signed [HW-1:0] g,
    output logic                 wb_vld,
    output logic [DTW-1:0]       wb_lo,
    output logic [DTW-1:0]       wb_hi
);

    logic [DTW-1:0] v [NV];
    logic [IXW-1:0] idx_hi;
    int             gi, wl, wh, st_lo, st_hi, n_lo, n_hi;

    // Weighted step for each bracketing vertex, then clamp.
    always_comb begin
        idx_hi = idx + IXW'(1);
        gi     = int'(g);
        wh     = int'(w);
        wl     = (1 << WW) - wh;
        st_lo  = (gi * wl) >>> (WW + GSH);
        st_hi  = (gi * wh) >>> (WW + GSH);
        n_lo   = clamp_i(int'(v[idx]) - st_lo, DT_MIN, DT_MAX);
        n_hi   = clamp_i(int'(v[idx_hi]) - st_hi, DT_MIN, DT_MAX);
    end

    // Store the two moved vertices and publish them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) v[i] <= DTW'(DT_INIT);
            wb_vld <= 1'b0;
            wb_lo  <= '0;
            wb_hi  <= '0;
        end else begin
            wb_vld <= upd;
            if (upd) begin
                v[idx]    <= DTW'(n_lo);
                v[idx_hi] <= DTW'(n_hi);
                wb_lo     <= DTW'(n_lo);
                wb_hi     <= DTW'(n_hi);
            end
        end
    end

endmodule

// File: rtl/es_deadtime_adapter.sv
// Top: two dead-time curves adapted by extremum seeking on a shared loss cost.
// Assumes: seg_idx <= NV-2; one accepted sample per smp_vld & en cycle.
module es_deadtime_adapter
    import es_pkg::*;
#(
    parameter int NV      = 4,
    parameter int DTW     = 8,
    parameter int LW      = 12,
    parameter int IW      = 8,
    parameter int WW      = 4,
    parameter int DLY     = 3,
    parameter int HALF0   = 4,
    parameter int HALF1   = 8,
    parameter int DISC    = 2,
    parameter int GSH     = 4,
    parameter int HPS     = 2,
    parameter int ONE_AMP = 16,
    parameter int AMP     = 2,
    parameter int DT_MIN  = 2,
    parameter int DT_MAX  = 200,
    parameter int DT_INIT = 64,
    localparam int IXW    = $clog2(NV),
    localparam int HW     = LW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 smp_vld,
    input  logic [LW-1:0]        loss,
    input  logic [IW-1:0]        iload,
    input  logic [IXW-1:0]       seg_idx,
    input  logic [WW-1:0]        seg_w,
    output logic [1:0][DTW-1:0]  dith,
    output logic [1:0]           wb_vld,
    output logic [IXW-1:0]       wb_idx,
    output logic [1:0][DTW-1:0]  wb_lo,
    output logic [1:0][DTW-1:0]  wb_hi
);

    logic                 adv;
    logic signed [HW-1:0] hp;

    assign adv = smp_vld & en;

    es_cost_hpf #(.LW(LW), .IW(IW), .ONE_AMP(ONE_AMP), .HPS(HPS)) i_cost (
        .clk(clk), .rst_n(rst_n), .adv(adv),
        .loss(loss), .iload(iload), .hp(hp)
    );

    // Index register shared by both channels' write-backs.
    always_ff @(posedge clk) begin
        if (!rst_n)   wb_idx <= '0;
        else if (adv) wb_idx <= seg_idx;
    end

    generate
        for (genvar k = 0; k < 2; k++) begin : g_ch
            localparam int HALF_K = (k == 0) ? HALF0 : HALF1;
            phase_t               ph_now, ph_lag;
            logic                 skip;
            logic signed [HW-1:0] g;

            es_dither_gen #(.HALF(HALF_K), .DLY(DLY), .DISC(DISC)) i_dith (
                .clk(clk), .rst_n(rst_n), .adv(adv),
                .ph_now(ph_now), .ph_lag(ph_lag), .skip(skip)
            );

            // Demodulate the cost with the lagged sign; drive the dither offset.
            always_comb begin
                g       = (ph_lag == PH_POS) ? hp : -hp;
                dith[k] = !en ? '0 :
                          ((ph_now == PH_POS) ? DTW'(AMP) : DTW'(-AMP));
            end

            es_vertex_bank #(
                .NV(NV), .DTW(DTW), .WW(WW), .HW(HW), .GSH(GSH),
                .DT_MIN(DT_MIN), .DT_MAX(DT_MAX), .DT_INIT(DT_INIT)
            ) i_bank (
                .clk(clk), .rst_n(rst_n), .upd(adv & ~skip),
                .idx(seg_idx), .w(seg_w), .g(g),
                .wb_vld(wb_vld[k]), .wb_lo(wb_lo[k]), .wb_hi(wb_hi[k])
            );
        end
    endgenerate

endmodule

// File: rtl/es_adapter_chk.sv
// Checker for the adapter's port-level rules; bound to every instance.
// Assumes: the same parameter values as the bound instance.
module es_adapter_chk #(
    parameter int NV     = 4,
    parameter int DTW    = 8,
    parameter int AMP    = 2,
    parameter int DT_MIN = 2,
    parameter int DT_MAX = 200,
    localparam int IXW   = $clog2(NV)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                en,
    input logic                smp_vld,
    input logic [IXW-1:0]      seg_idx,
    input logic [1:0][DTW-1:0] dith,
    input logic [1:0]          wb_vld,
    input logic [IXW-1:0]      wb_idx,
    input logic [1:0][DTW-1:0] wb_lo,
    input logic [1:0][DTW-1:0] wb_hi
);

    p_no_write_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_vld && en) |=> (wb_vld == 2'b00));

    p_dither_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (dith == '0));

    p_dither_amp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ((dith[0] == DTW'(AMP)) || (dith[0] == DTW'(-AMP))) &&
               ((dith[1] == DTW'(AMP)) || (dith[1] == DTW'(-AMP))));

    p_idx_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld != 2'b00) |-> (wb_idx == $past(seg_idx)));

    p_clamp_ch0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld[0] |-> (int'(wb_lo[0]) >= DT_MIN) && (int'(wb_lo[0]) <= DT_MAX) &&
                      (int'(wb_hi[0]) >= DT_MIN) && (int'(wb_hi[0]) <= DT_MAX));

    p_clamp_ch1_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_vld[1] |-> (int'(wb_lo[1]) >= DT_MIN) && (int'(wb_lo[1]) <= DT_MAX) &&
                      (int'(wb_hi[1]) >= DT_MIN) && (int'(wb_hi[1]) <= DT_MAX));

endmodule

bind es_deadtime_adapter es_adapter_chk #(
    .NV(NV), .DTW(DTW), .AMP(AMP), .DT_MIN(DT_MIN), .DT_MAX(DT_MAX)
) i_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld), .seg_idx(seg_idx),
    .dith(dith), .wb_vld(wb_vld), .wb_idx(wb_idx), .wb_lo(wb_lo), .wb_hi(wb_hi)
);

// File: tb/test_es_deadtime_adapter.sv
// Self-checking bench: arithmetic model of the adapter driven through sweeps.
module test_es_deadtime_adapter;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4, DTW = 8, LW = 12, IW = 8, WW = 4, DLY = 3;
    localparam int HALF0 = 4, HALF1 = 8, DISC = 2, GSH = 4, HPS = 2;
    localparam int ONE_AMP = 16, AMP = 2, DT_MIN = 2, DT_MAX = 200, DT_INIT = 64;
    localparam int IXW = $clog2(NV);
    localparam int WD_CYCLES = 150000;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                en = 1'b0;
    logic                smp_vld = 1'b0;
    logic [LW-1:0]       loss = '0;
    logic [IW-1:0]       iload = '0;
    logic [IXW-1:0]      seg_idx = '0;
    logic [WW-1:0]       seg_w = '0;
    logic [1:0][DTW-1:0] dith;
    logic [1:0]          wb_vld;
    logic [IXW-1:0]      wb_idx;
    logic [1:0][DTW-1:0] wb_lo;
    logic [1:0][DTW-1:0] wb_hi;

    es_deadtime_adapter i_es_deadtime_adapter (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_vld(smp_vld),
        .loss(loss), .iload(iload), .seg_idx(seg_idx), .seg_w(seg_w),
        .dith(dith), .wb_vld(wb_vld), .wb_idx(wb_idx),
        .wb_lo(wb_lo), .wb_hi(wb_hi)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Model state
    int mv [2][NV];
    int mavg, mcnt [2], ms [2], mdly [2][DLY], mld [2], mblk [2];
    // Pending expectations for the next negedge
    bit    pend = 1'b0, first = 1'b1;
    int    p_vld [2], p_lo [2], p_hi [2], p_idx;
    string p_tag [2];
    int    lfsr = 16'hACE1;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int half_of(input int k);
        return (k == 0) ? HALF0 : HALF1;
    endfunction

    function automatic int clampv(input int x);
        return (x < DT_MIN) ? DT_MIN : ((x > DT_MAX) ? DT_MAX : x);
    endfunction

    task automatic model_reset();
        mavg = 0;
        for (int k = 0; k < 2; k++) begin
            mcnt[k] = 0; ms[k] = 0; mld[k] = 0; mblk[k] = 0;
            for (int i = 0; i < DLY; i++) mdly[k][i] = 0;
            for (int i = 0; i < NV; i++) mv[k][i] = DT_INIT;
        end
    endtask

    // Check last sample's write-back, drive a new one, predict its result.
    task automatic do_sample(input bit e, input bit s, input int l, input int il,
                             input int ix, input int w);
        @(negedge clk);
        if (pend) begin
            for (int k = 0; k < 2; k++) begin
                chk(p_tag[k], int'(wb_vld[k]), p_vld[k]);
                if (p_vld[k] != 0) begin
                    chk(p_tag[k], int'(wb_lo[k]), p_lo[k]);
                    chk(p_tag[k], int'(wb_hi[k]), p_hi[k]);
                    chk("R8 idx", int'(wb_idx), p_idx);
                end
            end
        end
        en = e; smp_vld = s; loss = LW'(l); iload = IW'(il);
        seg_idx = IXW'(ix); seg_w = WW'(w);
        #1;
        for (int k = 0; k < 2; k++) begin
            if (!e) chk("R3 dither off", int'($signed(dith[k])), 0);
            else    chk(k == 0 ? "R2 dither" : "R2/R10 dither",
                        int'($signed(dith[k])), ms[k] != 0 ? -AMP : AMP);
        end
        pend = 1'b1;
        if (!(e && s)) begin
            for (int k = 0; k < 2; k++) begin
                p_vld[k] = 0;
                p_tag[k] = e ? "R8 no strobe" : "R3 hold";
            end
        end else begin
            int cost, hp;
            cost = (il > ONE_AMP) ? (l / il) : l;
            hp   = cost - mavg;
            p_idx = ix;
            for (int k = 0; k < 2; k++) begin
                int lag, g, slo, shi, rlo, rhi;
                bit skip;
                lag  = mdly[k][DLY-1];
                skip = (lag != mld[k]) || (mblk[k] != 0);
                g    = (lag == 0) ? hp : -hp;
                if (skip) begin
                    p_vld[k] = 0;
                    p_tag[k] = "R7 skip";
                end else begin
                    slo = (g * ((1 << WW) - w)) >>> (WW + GSH);
                    shi = (g * w) >>> (WW + GSH);
                    rlo = mv[k][ix] - slo;
                    rhi = mv[k][ix + 1] - shi;
                    p_vld[k] = 1;
                    p_lo[k]  = clampv(rlo);
                    p_hi[k]  = clampv(rhi);
                    mv[k][ix] = p_lo[k];
                    mv[k][ix + 1] = p_hi[k];
                    if (first)                               p_tag[k] = "R1 init vertex";
                    else if (rlo != p_lo[k] || rhi != p_hi[k]) p_tag[k] = "R9 clamp";
                    else p_tag[k] = (k == 0) ? "R4/R5/R6/R8" : "R4/R5/R6/R8/R10";
                end
                if (lag != mld[k])    mblk[k] = DISC - 1;
                else if (mblk[k] != 0) mblk[k]--;
                mld[k] = lag;
                for (int i = DLY - 1; i > 0; i--) mdly[k][i] = mdly[k][i-1];
                mdly[k][0] = ms[k];
                if (mcnt[k] == half_of(k) - 1) begin
                    ms[k] ^= 1; mcnt[k] = 0;
                end else mcnt[k]++;
            end
            mavg += hp >>> HPS;
            first = 1'b0;
        end
    endtask

    function automatic int next_lfsr(input int x);
        int b;
        b = ((x >> 0) ^ (x >> 2) ^ (x >> 3) ^ (x >> 5)) & 1;
        return ((x >> 1) | (b << 15)) & 16'hFFFF;
    endfunction

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        en = 1'b1;
        #1;
        chk("R1 reset wb_vld", int'(wb_vld), 0);
        chk("R1 reset dither", int'($signed(dith[0])), AMP);
        @(negedge clk);
        rst_n = 1'b1;
        // First sample with zero loss shows the reset vertex values.
        do_sample(1, 1, 0, 4, 0, 0);
        // Broad sweep: pseudo-random loss, current across the 1 A threshold,
        // every index and weight, occasional strobe gaps.
        for (int n = 0; n < 600; n++) begin
            lfsr = next_lfsr(lfsr);
            do_sample(1, (n % 7) != 6, lfsr & 12'hFFF, (n * 5) % 41,
                      n % (NV - 1), (n / 3) % 16);
        end
        // Enable low: strobes and loss must be ignored.
        for (int n = 0; n < 40; n++) begin
            lfsr = next_lfsr(lfsr);
            do_sample(0, n % 2, lfsr & 12'hFFF, 30, n % (NV - 1), n % 16);
        end
        // Loss correlated with channel 0 lag: drive its vertices to the floor.
        for (int n = 0; n < 200; n++)
            do_sample(1, 1, mdly[0][DLY-1] == 0 ? 4000 : 0, 8, n % (NV - 1), 8);
        // Anti-correlated: drive them to the ceiling.
        for (int n = 0; n < 300; n++)
            do_sample(1, 1, mdly[0][DLY-1] == 0 ? 0 : 4000, 8, n % (NV - 1), (n * 7) % 16);
        do_sample(1, 0, 0, 0, 0, 0);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R8 watchdog act=0 exp=1");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule